// File: doc/BRIEF.md
# AHB Slave Transfer Response Generator

This block is the data-phase controller of an AHB slave that holds a small word store. Each accepted transfer gets one of four endings. It can complete at once with OKAY, or complete with OKAY after a number of wait states set per transfer. It can also end with a two-cycle ERROR, RETRY or SPLIT. The block registers the address-phase signals and counts out the wait states. At the end of that wait it picks the ending and drives `hready_o` and `hresp_o` from flops.

The ending is chosen by fixed rules. A write that lands in a protected word window ends with ERROR. A request from the back end to defer ends with SPLIT. A busy indication ends with RETRY. Every other access completes with OKAY and performs the read or the write on the store. Wait states are always shown as OKAY with the ready line low. A non-OKAY code always appears first with the ready line low and then, in the next cycle, with the ready line high.

Top module: `ahb_resp_slave`

## Requirements
- R1: After reset, and in every cycle in which no transfer of this slave is in its data phase, `hready_o` is 1 and `hresp_o` is 2'b00 (OKAY). The response codes are: 00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT.
- R2: A transfer is accepted only at a clock edge where `hsel_i` is 1, `hreadyin_i` is 1 and `htrans_i` is 2'b10 (NONSEQ) or 2'b11 (SEQ). With `htrans_i` at 2'b00 (IDLE) or 2'b01 (BUSY), with `hsel_i` at 0, or with `hreadyin_i` at 0, the outputs stay as in R1.
- R3: When `cfg_wait_i` is 0 at acceptance, an OKAY transfer shows `hready_o`=1 with OKAY in the first cycle after the accepting edge.
- R4: When `cfg_wait_i` is W at acceptance, the first W data-phase cycles show `hready_o`=0 with OKAY. W is saturated to MAX_WAIT (default 16), so `cfg_wait_i` values above MAX_WAIT act as MAX_WAIT.
- R5: An ERROR, RETRY or SPLIT code appears with `hready_o`=1 only if the previous cycle showed the same code with `hready_o`=0. A code shown with `hready_o`=0 is always followed by the same code with `hready_o`=1.
- R6: A write whose word index (byte address bits [5:2] at default parameters) lies in the window RO_LO..RO_HI (default 8..11) ends with ERROR and leaves the store unchanged. Reads of that window complete with OKAY. ERROR takes priority over SPLIT and RETRY.
- R7: Outside the ERROR case, `split_i`=1 at the decision edge gives SPLIT, else `busy_i`=1 gives RETRY. The decision edge is the accepting edge when W is 0, and otherwise the edge that ends the last wait state. Neither ending writes the store.
- R8: An OKAY write stores `hwdata_i` at the edge that ends its last data cycle. An OKAY read returns the stored word on `hrdata_o` in its completing cycle. This includes a read accepted at the same edge that completes a write to the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel_i | input | 1 | Slave select |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 for write, 0 for read |
| haddr_i | input | ADDR_W | Byte address |
| hwdata_i | input | DATA_W | Write data for the transfer in its data phase |
| hreadyin_i | input | 1 | Bus ready: the previous transfer on the bus has completed |
| busy_i | input | 1 | Back end busy; asks for RETRY |
| split_i | input | 1 | Back end asks for SPLIT |
| cfg_wait_i | input | WAIT_W | Wait states for the transfer being accepted |
| hready_o | output | 1 | Data phase completes when 1 |
| hresp_o | output | 2 | Transfer response code |
| hrdata_o | output | DATA_W | Read data |

## Verification
The bench goes after four corner cases.

- **Two-phase ending.** A controller that ends an ERROR, RETRY or SPLIT in a single cycle lets the master complete the following address. A controller that drops the code before the ready cycle fails the every-cycle check against the reference model and the two-phase monitor.
- **Wait length.** Wait counts of 0, 3, exactly MAX_WAIT and above MAX_WAIT are applied. An off-by-one counter or a missing clamp shifts the completing cycle, and the bench sees a mismatch on that cycle.
- **Write followed at once by a read.** This is issued back to back to the same word. A store without bypass would return the old word.
- **Refused writes.** A protected-window write is sent, and so is a SPLIT write. The word is then read back, so a store that still wrote shows the changed value.

// File: rtl/ahb_resp_pkg.sv
package ahb_resp_pkg;

  typedef enum logic [1:0] {
    RSP_OKAY  = 2'b00,
    RSP_ERROR = 2'b01,
    RSP_RETRY = 2'b10,
    RSP_SPLIT = 2'b11
  } rsp_e;

  typedef enum logic [1:0] {
    PH_FREE,
    PH_WAIT,
    PH_HOLD,
    PH_LAST
  } phase_e;

endpackage

// File: rtl/ahb_resp_decide.sv
module ahb_resp_decide
  import ahb_resp_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int RO_LO = 8,
  parameter int RO_HI = 11
) (
  input  logic             is_write_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             busy_i,
  input  logic             split_i,
  output rsp_e             code_o
);

  logic in_window;

  generate
    if (RO_HI >= RO_LO) begin : g_window
      localparam logic [IDX_W-1:0] LO = IDX_W'(RO_LO);
      localparam logic [IDX_W-1:0] HI = IDX_W'(RO_HI);
      assign in_window = (idx_i >= LO) && (idx_i <= HI);
    end else begin : g_open
      logic unused_idx;
      assign unused_idx = ^idx_i;
      assign in_window  = 1'b0;
    end
  endgenerate

  always_comb begin
    if (is_write_i && in_window) begin
      code_o = RSP_ERROR;
    end else if (split_i) begin
      code_o = RSP_SPLIT;
    end else if (busy_i) begin
      code_o = RSP_RETRY;
    end else begin
      code_o = RSP_OKAY;
    end
  end

endmodule

// File: rtl/ahb_resp_fsm.sv
module ahb_resp_fsm
  import ahb_resp_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int MAX_WAIT = 16,
  parameter int WAIT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel_i,
  input  logic              trans_active_i,
  input  logic              hreadyin_i,
  input  logic              hwrite_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  input  rsp_e              code_i,
  output logic              dec_write_o,
  output logic [IDX_W-1:0]  dec_idx_o,
  output logic              hready_o,
  output logic [1:0]        hresp_o,
  output logic              mem_we_o,
  output logic [IDX_W-1:0]  mem_widx_o,
  output logic              mem_re_o
);

  localparam logic [WAIT_W-1:0] MAX_W = WAIT_W'(MAX_WAIT);
  localparam logic [WAIT_W-1:0] ONE_W = WAIT_W'(1);

  phase_e            ph_q, ph_d;
  rsp_e              rsp_q, rsp_d;
  logic              rdy_q, rdy_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic              wr_q, wr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pend_q, pend_d;
  logic [WAIT_W-1:0] wait_eff;
  logic              accept;
  logic              settle;

  assign wait_eff = (cfg_wait_i > MAX_W) ? MAX_W : cfg_wait_i;
  assign accept   = hsel_i && trans_active_i && hreadyin_i &&
                    ((ph_q == PH_FREE) || (ph_q == PH_LAST));

  assign dec_write_o = (ph_q == PH_WAIT) ? wr_q  : hwrite_i;
  assign dec_idx_o   = (ph_q == PH_WAIT) ? idx_q : idx_i;

  always_comb begin
    ph_d   = ph_q;
    rdy_d  = rdy_q;
    rsp_d  = rsp_q;
    cnt_d  = cnt_q;
    wr_d   = wr_q;
    idx_d  = idx_q;
    pend_d = 1'b0;
    settle = 1'b0;
    case (ph_q)
      PH_FREE, PH_LAST: begin
        if (accept) begin
          wr_d  = hwrite_i;
          idx_d = idx_i;
          if (wait_eff == '0) begin
            settle = 1'b1;
          end else begin
            ph_d  = PH_WAIT;
            rdy_d = 1'b0;
            rsp_d = RSP_OKAY;
            cnt_d = wait_eff - ONE_W;
          end
        end else begin
          ph_d  = PH_FREE;
          rdy_d = 1'b1;
          rsp_d = RSP_OKAY;
        end
      end
      PH_WAIT: begin
        if (cnt_q == '0) begin
          settle = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE_W;
        end
      end
      PH_HOLD: begin
        ph_d  = PH_LAST;
        rdy_d = 1'b1;
      end
      default: begin
        ph_d = PH_FREE;
      end
    endcase
    if (settle) begin
      if (code_i == RSP_OKAY) begin
        ph_d   = PH_LAST;
        rdy_d  = 1'b1;
        rsp_d  = RSP_OKAY;
        pend_d = dec_write_o;
      end else begin
        ph_d  = PH_HOLD;
        rdy_d = 1'b0;
        rsp_d = code_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_FREE;
      rsp_q  <= RSP_OKAY;
      rdy_q  <= 1'b1;
      cnt_q  <= '0;
      wr_q   <= 1'b0;
      idx_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      rsp_q  <= rsp_d;
      rdy_q  <= rdy_d;
      cnt_q  <= cnt_d;
      wr_q   <= wr_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
    end
  end

  assign hready_o   = rdy_q;
  assign hresp_o    = rsp_q;
  assign mem_we_o   = pend_q && (ph_q == PH_LAST);
  assign mem_widx_o = idx_q;
  assign mem_re_o   = accept;

  // Run length of consecutive low-ready cycles, for the wait bound check
  logic [WAIT_W:0] low_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      low_run <= '0;
    end else if (!rdy_q) begin
      low_run <= low_run + 1'b1;
    end else begin
      low_run <= '0;
    end
  end

  assert_idle_okay_R1: assert property (@(posedge clk) disable iff (rst)
    (hready_o && !accept) |=> (hready_o && hresp_o == 2'b00));

  assert_zero_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (accept && cfg_wait_i == '0 && code_i == RSP_OKAY) |=> hready_o);

  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (rst)
    int'(low_run) <= MAX_WAIT + 1);

  assert_hold_then_done_R5: assert property (@(posedge clk) disable iff (rst)
    (!hready_o && hresp_o != 2'b00) |=> (hready_o && $stable(hresp_o)));

  assert_done_has_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (hready_o && hresp_o != 2'b00) |-> (!$past(hready_o) && $past(hresp_o) == hresp_o));

endmodule

// File: rtl/ahb_resp_store.sv
module ahb_resp_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter bit BYPASS = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              fwd;

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[widx_i] <= wdata_i;
    end
  end

  generate
    if (BYPASS) begin : g_bypass
      assign fwd = we_i && (widx_i == ridx_i);
    end else begin : g_plain
      assign fwd = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (re_i) begin
      rdata_q <= fwd ? wdata_i : mem[ridx_i];
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ahb_resp_slave.sv
module ahb_resp_slave
  import ahb_resp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int DEPTH    = 16,
  parameter int MAX_WAIT = 16,
  parameter int WAIT_W   = $clog2(MAX_WAIT + 1),
  parameter int RO_LO    = 8,
  parameter int RO_HI    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hsel_i,
  input  logic [1:0]        htrans_i,
  input  logic              hwrite_i,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [DATA_W-1:0] hwdata_i,
  input  logic              hreadyin_i,
  input  logic              busy_i,
  input  logic              split_i,
  input  logic [WAIT_W-1:0] cfg_wait_i,
  output logic              hready_o,
  output logic [1:0]        hresp_o,
  output logic [DATA_W-1:0] hrdata_o
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int LSB   = $clog2(DATA_W / 8);

  logic [IDX_W-1:0] idx_in;
  logic             dec_write;
  logic [IDX_W-1:0] dec_idx;
  rsp_e             code;
  logic             mem_we;
  logic [IDX_W-1:0] mem_widx;
  logic             mem_re;
  logic             unused_bits;

  assign idx_in      = haddr_i[LSB +: IDX_W];
  assign unused_bits = ^{haddr_i[ADDR_W-1:LSB+IDX_W], haddr_i[LSB-1:0], htrans_i[0]};

  ahb_resp_decide #(
    .IDX_W (IDX_W),
    .RO_LO (RO_LO),
    .RO_HI (RO_HI)
  ) decide_i (
    .is_write_i (dec_write),
    .idx_i      (dec_idx),
    .busy_i     (busy_i),
    .split_i    (split_i),
    .code_o     (code)
  );

  ahb_resp_fsm #(
    .IDX_W    (IDX_W),
    .MAX_WAIT (MAX_WAIT),
    .WAIT_W   (WAIT_W)
  ) fsm_i (
    .clk            (clk),
    .rst            (rst),
    .hsel_i         (hsel_i),
    .trans_active_i (htrans_i[1]),
    .hreadyin_i     (hreadyin_i),
    .hwrite_i       (hwrite_i),
    .idx_i          (idx_in),
    .cfg_wait_i     (cfg_wait_i),
    .code_i         (code),
    .dec_write_o    (dec_write),
    .dec_idx_o      (dec_idx),
    .hready_o       (hready_o),
    .hresp_o        (hresp_o),
    .mem_we_o       (mem_we),
    .mem_widx_o     (mem_widx),
    .mem_re_o       (mem_re)
  );

  ahb_resp_store #(
    .DATA_W (DATA_W),
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .BYPASS (1'b1)
  ) store_i (
    .clk     (clk),
    .rst     (rst),
    .we_i    (mem_we),
    .widx_i  (mem_widx),
    .wdata_i (hwdata_i),
    .re_i    (mem_re),
    .ridx_i  (idx_in),
    .rdata_o (hrdata_o)
  );

  assert_write_only_okay_R8: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (hready_o && hresp_o == 2'b00));

  assert_refused_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    (hready_o && hresp_o != 2'b00) |-> !mem_we);

endmodule

// File: tb/ahb_resp_slave_tb.sv
module ahb_resp_slave_tb_top;

  localparam int DATA_W   = 32;
  localparam int DEPTH    = 16;
  localparam int MAX_WAIT = 16;
  localparam int WAIT_W   = 5;
  localparam int RO_LO    = 8;
  localparam int RO_HI    = 11;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              hsel = 1'b0;
  logic [1:0]        htrans = 2'b00;
  logic              hwrite = 1'b0;
  logic [31:0]       haddr = '0;
  logic [DATA_W-1:0] hwdata = '0;
  logic              blk = 1'b0;
  logic              busy = 1'b0;
  logic              split = 1'b0;
  logic [WAIT_W-1:0] cfg_wait = '0;
  logic              hready;
  logic [1:0]        hresp;
  logic [DATA_W-1:0] hrdata;
  logic              hreadyin;

  assign hreadyin = hready && !blk;

  always #5 clk = ~clk;

  ahb_resp_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .hsel_i     (hsel),
    .htrans_i   (htrans),
    .hwrite_i   (hwrite),
    .haddr_i    (haddr),
    .hwdata_i   (hwdata),
    .hreadyin_i (hreadyin),
    .busy_i     (busy),
    .split_i    (split),
    .cfg_wait_i (cfg_wait),
    .hready_o   (hready),
    .hresp_o    (hresp),
    .hrdata_o   (hrdata)
  );

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    finished = 0;

  // Reference model: per-cycle expectations from a queue
  bit          q_rdy[$];
  logic [1:0]  q_rsp[$];
  bit          q_rd[$];
  bit          exp_rdy = 1;
  logic [1:0]  exp_rsp = 2'b00;
  bit          exp_rd = 0;
  logic [DATA_W-1:0] mmem [DEPTH];
  bit          mknown [DEPTH];
  bit          m_wpend = 0;
  int          m_wr_idx = 0;
  int          m_rd_idx = 0;
  logic [DATA_W-1:0] exp_data = '0;
  int          m_w;
  int          m_ix;
  logic [1:0]  m_code;

  initial begin
    for (int i = 0; i < DEPTH; i++) mknown[i] = 0;
  end

  always @(posedge clk) begin
    if (rst) begin
      q_rdy.delete(); q_rsp.delete(); q_rd.delete();
      exp_rdy = 1; exp_rsp = 2'b00; exp_rd = 0; m_wpend = 0;
    end else begin
      if (exp_rdy && m_wpend) begin
        mmem[m_wr_idx] = hwdata;
        mknown[m_wr_idx] = 1;
        m_wpend = 0;
      end
      if (exp_rdy && hsel && htrans[1] && !blk) begin
        m_w  = (int'(cfg_wait) > MAX_WAIT) ? MAX_WAIT : int'(cfg_wait);
        m_ix = int'(haddr[5:2]);
        if (hwrite && m_ix >= RO_LO && m_ix <= RO_HI) m_code = 2'b01;
        else if (split) m_code = 2'b11;
        else if (busy) m_code = 2'b10;
        else m_code = 2'b00;
        for (int k = 0; k < m_w; k++) begin
          q_rdy.push_back(0); q_rsp.push_back(2'b00); q_rd.push_back(0);
        end
        if (m_code == 2'b00) begin
          q_rdy.push_back(1); q_rsp.push_back(2'b00); q_rd.push_back(!hwrite);
          if (hwrite) begin
            m_wpend = 1; m_wr_idx = m_ix;
          end else begin
            m_rd_idx = m_ix; exp_data = mmem[m_ix];
          end
        end else begin
          q_rdy.push_back(0); q_rsp.push_back(m_code); q_rd.push_back(0);
          q_rdy.push_back(1); q_rsp.push_back(m_code); q_rd.push_back(0);
        end
      end
      if (q_rdy.size() > 0) begin
        exp_rdy = q_rdy.pop_front();
        exp_rsp = q_rsp.pop_front();
        exp_rd  = q_rd.pop_front();
      end else begin
        exp_rdy = 1; exp_rsp = 2'b00; exp_rd = 0;
      end
    end
  end

  // Comparison on every cycle, away from the active edge
  bit         prev_rdy = 1;
  logic [1:0] prev_rsp = 2'b00;
  always @(negedge clk) begin
    if (!rst && !finished) begin
      checks++;
      if (hready !== exp_rdy || hresp !== exp_rsp) begin
        errors++;
        $display("FAIL %s: hready/hresp got %b/%b expected %b/%b at %0t",
                 cur_req, hready, hresp, exp_rdy, exp_rsp, $time);
      end
      if (hready && hresp != 2'b00) begin
        checks++;
        if (prev_rdy || prev_rsp != hresp) begin
          errors++;
          $display("FAIL R5: code %b with ready high after %b/%b expected %b with ready low",
                   hresp, prev_rdy, prev_rsp, hresp);
        end
      end
      if (exp_rdy && exp_rd) begin
        if (!mknown[m_rd_idx]) begin
          mmem[m_rd_idx] = hrdata;
          mknown[m_rd_idx] = 1;
        end else begin
          checks++;
          if (hrdata !== exp_data) begin
            errors++;
            $display("FAIL %s: hrdata word %0d got %h expected %h",
                     cur_req, m_rd_idx, hrdata, exp_data);
          end
        end
      end
      prev_rdy = hready;
      prev_rsp = hresp;
    end
  end

  // Sequence descriptors for the pipelined driver
  logic [31:0]       s_addr [8];
  bit                s_wr   [8];
  logic [DATA_W-1:0] s_wd   [8];
  int                s_w    [8];

  task automatic set_x(input int i, input bit wr, input int idx,
                       input logic [DATA_W-1:0] wd, input int w);
    s_addr[i] = 32'(idx * 4);
    s_wr[i]   = wr;
    s_wd[i]   = wd;
    s_w[i]    = w;
  endtask

  task automatic run_seq(input int n);
    int ai = 0;
    int di = -1;
    bit rdy;
    while (ai < n || di >= 0) begin
      @(negedge clk);
      rdy = hready;
      if (di >= 0) hwdata = s_wd[di];
      if (ai < n) begin
        hsel = 1; htrans = 2'b10; haddr = s_addr[ai];
        hwrite = s_wr[ai]; cfg_wait = WAIT_W'(s_w[ai]);
      end else begin
        hsel = 0; htrans = 2'b00;
      end
      if (rdy) begin
        di = (ai < n) ? ai : -1;
        if (ai < n) ai++;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsel = 0; htrans = 2'b00; blk = 0;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (hready !== 1'b1 || hresp !== 2'b00) begin
      errors++;
      $display("FAIL R1: after reset got %b/%b expected 1/00", hready, hresp);
    end
    idle(3);

    // R2: non-accepted address phases
    cur_req = "R2";
    @(negedge clk); hsel = 1; htrans = 2'b00; hwrite = 1; haddr = 32'h4;
    @(negedge clk); htrans = 2'b01;
    @(negedge clk); hsel = 0; htrans = 2'b10;
    @(negedge clk); hsel = 1; htrans = 2'b10; blk = 1; cfg_wait = 5'd2;
    idle(3);

    // R3: zero-wait writes then reads, pipelined
    cur_req = "R3";
    for (int i = 0; i < 4; i++) set_x(i, 1, i, 32'hA000_0000 + 32'(i * 17), 0);
    for (int i = 0; i < 4; i++) set_x(4 + i, 0, i, '0, 0);
    run_seq(8);
    idle(2);

    // R4: wait lengths 3, MAX_WAIT, and above MAX_WAIT (clamped)
    cur_req = "R4";
    set_x(0, 1, 5, 32'h5555_1234, 3); set_x(1, 0, 5, '0, 3); run_seq(2);
    set_x(0, 0, 2, '0, MAX_WAIT); run_seq(1);
    set_x(0, 1, 6, 32'hC0DE_0006, 31); set_x(1, 0, 6, '0, 20); run_seq(2);
    idle(2);

    // R8: write then read of the same word, back to back
    cur_req = "R8";
    set_x(0, 1, 3, 32'hFEED_0003, 0); set_x(1, 0, 3, '0, 0); run_seq(2);
    set_x(0, 1, 3, 32'hBEEF_1003, 2); set_x(1, 0, 3, '0, 1); run_seq(2);
    idle(2);

    // R6: protected window
    cur_req = "R6";
    set_x(0, 0, 9, '0, 0); run_seq(1);
    set_x(0, 1, 9, 32'h1111_2222, 0); run_seq(1); idle(1);
    set_x(0, 1, 9, 32'h3333_4444, 2); run_seq(1); idle(1);
    busy = 1; split = 1;
    set_x(0, 1, 10, 32'h7777_0000, 1); run_seq(1); idle(1);
    busy = 0; split = 0;
    set_x(0, 0, 9, '0, 0); set_x(1, 0, 10, '0, 0); run_seq(2);
    idle(2);

    // R7: SPLIT and RETRY selection
    cur_req = "R7";
    split = 1; set_x(0, 1, 2, 32'hDEAD_0002, 0); run_seq(1); split = 0; idle(1);
    busy = 1;  set_x(0, 0, 1, '0, 4); run_seq(1); idle(1);
    split = 1; set_x(0, 0, 1, '0, 0); run_seq(1); idle(1);
    busy = 0; split = 0;
    set_x(0, 0, 2, '0, 0); set_x(1, 0, 1, '0, 0); run_seq(2);
    idle(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not end, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule